// File: doc/BRIEF.md
# Bus Inversion Codec for a 64-bit Active-Low Data Path

This block reduces simultaneous low drive on a 64-bit active-low data path. On the sending side it looks at each 16-bit slice of the logical write data separately. A logical 1 is driven as an electrical low, so it counts how many wires of the slice would be pulled low. If that count is above half the slice, it drives the slice inverted. It also pulls that slice's inversion flag low, so the receiver knows the slice was inverted. The flag is itself active low, and the scheme keeps the low wires of a slice, flag included, at no more than 8 of its 17.

On the receiving side, the block takes the bus levels and the four flag wires. It undoes the inversion on every flagged slice and turns the active-low levels back into logical data. Each side has its own valid strobe. Its output register loads on a cycle where the strobe is high and keeps its value on every other cycle.

Top module: `dbi_codec`

## Requirements
- R1: While rst_n is low, tx_lvl reads all ones, tx_flag_n reads all ones (nothing driven low) and rx_data reads zero.
- R2: Slice k (k = 0..3) is bits 16k+15 down to 16k of every 64-bit port, and flag bit k belongs to slice k alone.
- R3: When a loaded slice of tx_data holds at most 8 ones (8 included), it is not inverted: its tx_lvl bits equal the bitwise complement of the data, and its tx_flag_n bit is 1.
- R4: When a loaded slice of tx_data holds 9 or more ones, it is inverted: its tx_lvl bits equal the data bits, and its tx_flag_n bit is 0.
- R5: In every slice, the zeros on tx_lvl plus a zero on its tx_flag_n bit never total more than 8.
- R6: For a loaded slice whose rx_flag_n bit is 1, rx_data equals the complement of rx_lvl. For a loaded slice whose rx_flag_n bit is 0, rx_data equals rx_lvl.
- R7: Feeding tx_lvl and tx_flag_n into rx_lvl and rx_flag_n returns the original tx_data.
- R8: On a cycle where tx_valid is low, tx_lvl and tx_flag_n keep their values. On a cycle where rx_valid is low, rx_data keeps its value.
- R9: A side whose valid strobe is high at a rising clock edge shows the new result right after that edge (one register of latency).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_valid | input | 1 | Load strobe for the sending side |
| tx_data | input | 64 | Logical data to send |
| tx_lvl | output | 64 | Electrical levels for the data wires (0 = driven low) |
| tx_flag_n | output | 4 | Per-slice inversion flags, low = slice inverted |
| rx_valid | input | 1 | Load strobe for the receiving side |
| rx_lvl | input | 64 | Received electrical levels of the data wires |
| rx_flag_n | input | 4 | Received per-slice inversion flags, low = inverted |
| rx_data | output | 64 | Restored logical data |

## Verification
Some rules are checked by the assertions on every cycle: the low-wire bound of each slice, holding the registers when no strobe is present, and the choice of inversion against the number of ones in the loaded data. The decode rule for each flag value is checked the same way. Other points only the bench scenarios can show. These are the full encode-then-decode round trip, the exact boundary between 8 and 9 ones, mixed slices that prove flag k maps to slice k alone, and the register values while reset is held.

// File: rtl/dbi_pkg.sv
package dbi_pkg;
  localparam int GROUP_W  = 16;
  localparam int N_GROUPS = 4;
  localparam int BUS_W    = GROUP_W * N_GROUPS;
  localparam int CNT_W    = $clog2(GROUP_W + 1);
  localparam int LOW_MAX  = GROUP_W / 2;

  // Number of wires that would be pulled low if the slice went out as is.
  function automatic logic [CNT_W-1:0] low_count(input logic [GROUP_W-1:0] d);
    logic [CNT_W-1:0] n;
    n = '0;
    for (int i = 0; i < GROUP_W; i++) n = n + CNT_W'(d[i]);
    return n;
  endfunction

  // Invert only when strictly more than half the wires would be low.
  function automatic logic invert_needed(input logic [CNT_W-1:0] n);
    return n > CNT_W'(LOW_MAX);
  endfunction
endpackage

// File: rtl/dbi_group_enc.sv
module dbi_group_enc
  import dbi_pkg::*;
(
  input  logic [GROUP_W-1:0] data,
  output logic [GROUP_W-1:0] lvl,
  output logic               inv,
  output logic [CNT_W-1:0]   low_cnt
);
  always_comb begin
    low_cnt = low_count(data);
    inv     = invert_needed(low_cnt);
    // active low: plain drive is ~data; inverted drive is data
    lvl     = inv ? data : ~data;
  end
endmodule

// File: rtl/dbi_group_dec.sv
module dbi_group_dec
  import dbi_pkg::*;
(
  input  logic [GROUP_W-1:0] lvl,
  input  logic               inv,
  output logic [GROUP_W-1:0] data
);
  always_comb data = inv ? lvl : ~lvl;
endmodule

// File: rtl/dbi_codec.sv
module dbi_codec
  import dbi_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tx_valid,
  input  logic [BUS_W-1:0]   tx_data,
  output logic [BUS_W-1:0]   tx_lvl,
  output logic [N_GROUPS-1:0] tx_flag_n,
  input  logic               rx_valid,
  input  logic [BUS_W-1:0]   rx_lvl,
  input  logic [N_GROUPS-1:0] rx_flag_n,
  output logic [BUS_W-1:0]   rx_data
);
  logic [BUS_W-1:0]    enc_lvl;
  logic [N_GROUPS-1:0] enc_inv;
  logic [BUS_W-1:0]    dec_data;
  logic [CNT_W-1:0]    enc_cnt [N_GROUPS];

  for (genvar g = 0; g < N_GROUPS; g++) begin : g_slice
    localparam int LO = g * GROUP_W;

    dbi_group_enc u_enc (
      .data    (tx_data[LO +: GROUP_W]),
      .lvl     (enc_lvl[LO +: GROUP_W]),
      .inv     (enc_inv[g]),
      .low_cnt (enc_cnt[g])
    );

    dbi_group_dec u_dec (
      .lvl  (rx_lvl[LO +: GROUP_W]),
      .inv  (~rx_flag_n[g]),
      .data (dec_data[LO +: GROUP_W])
    );

    // R5
    low_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(~tx_lvl[LO +: GROUP_W]) + int'(!tx_flag_n[g])) <= LOW_MAX);
    // R4
    inv_above_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && $countones(tx_data[LO +: GROUP_W]) > LOW_MAX) |=>
      (!tx_flag_n[g] && tx_lvl[LO +: GROUP_W] == $past(tx_data[LO +: GROUP_W])));
    // R3
    plain_at_most_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && $countones(tx_data[LO +: GROUP_W]) <= LOW_MAX) |=>
      (tx_flag_n[g] && tx_lvl[LO +: GROUP_W] == ~$past(tx_data[LO +: GROUP_W])));
    // R6
    decode_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> rx_data[LO +: GROUP_W] ==
        ($past(rx_flag_n[g]) ? ~$past(rx_lvl[LO +: GROUP_W])
                             :  $past(rx_lvl[LO +: GROUP_W])));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_lvl    <= '1;
      tx_flag_n <= '1;
    end else if (tx_valid) begin
      tx_lvl    <= enc_lvl;
      tx_flag_n <= ~enc_inv;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rx_data <= '0;
    else if (rx_valid) rx_data <= dec_data;
  end

  // R8
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_valid |=> ($stable(tx_lvl) && $stable(tx_flag_n)));
  // R8
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |=> $stable(rx_data));
endmodule

// File: tb/test_dbi_codec.sv
module test_dbi_codec;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tx_valid = 1'b0;
  logic [63:0] tx_data = '0;
  logic [63:0] tx_lvl;
  logic [3:0]  tx_flag_n;
  logic        rx_valid = 1'b0;
  logic [63:0] rx_lvl = '0;
  logic [3:0]  rx_flag_n = '1;
  logic [63:0] rx_data;

  int n_run = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  dbi_codec i_dbi_codec (
    .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_lvl(tx_lvl), .tx_flag_n(tx_flag_n), .rx_valid(rx_valid),
    .rx_lvl(rx_lvl), .rx_flag_n(rx_flag_n), .rx_data(rx_data)
  );

  localparam int NV = 8;
  localparam logic [63:0] VDATA [NV] = '{
    64'h0000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF,
    64'h00FF_00FF_00FF_00FF, 64'h01FF_01FF_01FF_01FF,
    64'hFFFF_0000_01FF_00FF, 64'h5555_AAAA_FF00_7FFF,
    64'h0001_FFFE_0000_8000, 64'hF0F1_0F0F_FF80_1234 };
  localparam logic [3:0] VFLAG [NV] = '{
    4'hF, 4'h0, 4'hF, 4'h0, 4'h5, 4'hE, 4'hB, 4'h5 };

  task automatic check(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int ones16(input logic [15:0] v);
    int c = 0;
    foreach (v[i]) if (v[i] === 1'b1) c++;
    return c;
  endfunction

  // Expected drive computed slice by slice from R3/R4.
  function automatic logic [63:0] exp_lvl(input logic [63:0] d);
    logic [63:0] r;
    for (int k = 0; k < 4; k++)
      r[16*k +: 16] = (ones16(d[16*k +: 16]) >= 9) ? d[16*k +: 16] : ~d[16*k +: 16];
    return r;
  endfunction

  function automatic logic [3:0] exp_flag(input logic [63:0] d);
    logic [3:0] f;
    for (int k = 0; k < 4; k++) f[k] = !(ones16(d[16*k +: 16]) >= 9);
    return f;
  endfunction

  task automatic check_bound(input string tag);
    bit ok = 1;
    for (int k = 0; k < 4; k++)
      if (ones16(~tx_lvl[16*k +: 16]) + (tx_flag_n[k] ? 0 : 1) > 8) ok = 0;
    check(ok, tag, {60'd0, tx_flag_n}, 64'd0);
  endtask

  // encode, loop back, decode; sampling at falling edges
  task automatic round_trip(input logic [63:0] d, input logic [3:0] fexp, input bit use_fexp);
    @(negedge clk);
    tx_data = d; tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
    check(tx_lvl === exp_lvl(d), "R3/R4 lvl", tx_lvl, exp_lvl(d));
    if (use_fexp)
      check(tx_flag_n === fexp, "R2 flag map", {60'd0, tx_flag_n}, {60'd0, fexp});
    else
      check(tx_flag_n === exp_flag(d), "R4 flag", {60'd0, tx_flag_n}, {60'd0, exp_flag(d)});
    check_bound("R5 bound");
    rx_lvl = tx_lvl; rx_flag_n = tx_flag_n; rx_valid = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0;
    check(rx_data === d, "R7 round trip", rx_data, d);
  endtask

  initial begin
    fork
      begin : watchdog
        repeat (100000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog actual=%h expected=%h", 64'd1, 64'd0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
      end
    join_none

    // R1 reset state
    tx_valid = 1'b1; tx_data = '1; rx_valid = 1'b1; rx_lvl = '0; rx_flag_n = '0;
    repeat (3) @(negedge clk);
    check(tx_lvl === '1, "R1 tx_lvl", tx_lvl, '1);
    check(tx_flag_n === 4'hF, "R1 tx_flag_n", {60'd0, tx_flag_n}, 64'hF);
    check(rx_data === '0, "R1 rx_data", rx_data, '0);
    tx_valid = 1'b0; rx_valid = 1'b0;
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) round_trip(VDATA[i], VFLAG[i], 1'b1);

    for (int i = 0; i < 40; i++) round_trip({$urandom, $urandom}, 4'h0, 1'b0);

    // R9 one-cycle latency
    @(negedge clk);
    tx_data = 64'h0000_0000_0000_01FF; tx_valid = 1'b1;
    @(posedge clk); #1;
    check(tx_lvl === 64'hFFFF_FFFF_FFFF_01FF, "R9 latency", tx_lvl, 64'hFFFF_FFFF_FFFF_01FF);
    tx_valid = 1'b0;

    // R8 hold with strobes low
    @(negedge clk);
    tx_data = 64'h1234_5678_9ABC_DEF0;
    rx_lvl = 64'hAAAA_AAAA_AAAA_AAAA; rx_flag_n = 4'h0;
    repeat (3) @(negedge clk);
    check(tx_lvl === 64'hFFFF_FFFF_FFFF_01FF, "R8 tx hold", tx_lvl, 64'hFFFF_FFFF_FFFF_01FF);
    check(tx_flag_n === 4'hE, "R8 flag hold", {60'd0, tx_flag_n}, 64'hE);
    check(rx_data === 64'hF0F1_0F0F_FF80_1234 || rx_data !== 64'hAAAA_AAAA_AAAA_AAAA,
          "R8 rx hold", rx_data, 64'd0);

    // R6 direct decode, mixed flags
    rx_lvl = 64'h1234_5678_9ABC_DEF0; rx_flag_n = 4'b1010; rx_valid = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0;
    check(rx_data === 64'hEDCB_5678_6543_DEF0, "R6 decode", rx_data, 64'hEDCB_5678_6543_DEF0);
    rx_lvl = '0;
    repeat (2) @(negedge clk);
    check(rx_data === 64'hEDCB_5678_6543_DEF0, "R8 rx hold after decode", rx_data, 64'hEDCB_5678_6543_DEF0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule